// File: doc/BRIEF.md
# Protected-Config Watchdog Timer

This block is a watchdog for a power-management domain. Software arms it by writing a 16-bit timeout to a configuration register. From then on, each pulse on the tick input counts the watchdog down by one. Software must keep restarting the countdown by writing a fixed 32-bit key to a separate feed register. If the count runs out, the block asks for a system reset with a single-clock pulse, reloads itself and keeps guarding.

Both control writes are guarded against stray or corrupted stores. A configuration word is accepted only when its upper half is the exact bitwise inverse of its lower half. A rejected configuration word leaves the settings alone and raises a sticky error flag. A feed write counts only when its data equals the key 0xA55A55AA; any other data does nothing. A timeout of zero disarms the watchdog. The register bus is a plain single-cycle write strobe with byte address and write data. Read data is combinational from the address.

Top module: `wdg_guard`

## Requirements
- R1: After a synchronous active-low reset the timeout is 0, the count is 0, the error flag is clear, `sys_rst_req` is low, and the watchdog is disarmed.
- R2: A write to the config register at offset 0x0 whose bits 31:16 equal the inverse of bits 15:0 loads bits 15:0 as the timeout and loads the count with that value. Reading offset 0x0 returns {~timeout, timeout}.
- R3: A config write whose bits 31:16 are not the inverse of bits 15:0 leaves the timeout and count unchanged and sets the error flag, which is bit 31 of the status register at offset 0x8.
- R4: While the timeout is non-zero, each clock with `tick` high lowers the count by one. Clocks without `tick` leave the count unchanged. Status bits 15:0 hold the count.
- R5: A write to the feed register at offset 0x4 with any data other than 0xA55A55AA changes nothing.
- R6: A write of 0xA55A55AA to the feed register reloads the count with the timeout.
- R7: A tick that arrives while the count is 1 makes `sys_rst_req` high for exactly the next clock cycle and reloads the count with the timeout.
- R8: When a tick and a write arrive in the same cycle, a valid config write wins over a feed, and a feed wins over the tick. A feed on the expiring tick therefore prevents the reset request.
- R9: A valid config write clears the error flag.
- R10: With timeout 0, ticks and feeds leave the count at 0 and `sys_rst_req` never rises.
- R11: Reads of the feed offset and of unmapped offsets return 0. Status bits 30:16 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| addr | input | 4 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| tick | input | 1 | Countdown enable pulse |
| sys_rst_req | output | 1 | One-cycle system reset request on expiry |

## Verification
The bench aims at the two guard checks with near-miss words. It writes a config word with the upper half off by one bit and a feed key with its last bit flipped. A design that compared too loosely would retime the watchdog or restart the countdown, and the status readback would show it. It lands a feed on the very tick that would expire the count. A design that ordered the feed below the tick would emit a reset request. It also lands a config write on a tick: a wrong design would show a decremented new count. A design that stretched the reset pulse, or counted while disarmed, would break the per-cycle request checks and the total number of pulses over the run.

// File: rtl/wdg_pkg.sv
// Package: shared widths, the feed key, register selector type and
// helpers for the inverse-pattern guard on configuration words.
package wdg_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned HALF_W = BUS_W / 2;

    localparam logic [BUS_W-1:0] FEED_KEY = 32'hA55A55AA;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_FEED = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } wdg_sel_e;

    // True when the upper half is the bitwise inverse of the lower half.
    function automatic logic cfg_word_ok(input logic [BUS_W-1:0] w);
        return w[BUS_W-1:HALF_W] == ~w[HALF_W-1:0];
    endfunction

    // Builds the readback image of a timeout: inverse on top, value below.
    function automatic logic [BUS_W-1:0] cfg_image(input logic [HALF_W-1:0] t);
        return {~t, t};
    endfunction

endpackage

// File: rtl/wdg_addr_map.sv
// Module: wdg_addr_map
// Turns a byte offset into a register selector.
// Assumes the three offsets are distinct; any other offset selects nothing.
module wdg_addr_map
    import wdg_pkg::*;
#(
    parameter int unsigned      ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] CFG_OFS  = 'h0,
    parameter logic [ADDR_W-1:0] FEED_OFS = 'h4,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h8
) (
    input  logic [ADDR_W-1:0] addr,
    output wdg_sel_e          sel
);

    // Offset compare, config first.
    always_comb begin
        if (addr == CFG_OFS)       sel = SEL_CFG;
        else if (addr == FEED_OFS) sel = SEL_FEED;
        else if (addr == STAT_OFS) sel = SEL_STAT;
        else                       sel = SEL_NONE;
    end

endmodule

// File: rtl/wdg_wr_qual.sv
// Module: wdg_wr_qual
// Qualifies bus writes into single-cycle strobes: accepted config,
// rejected config and valid feed. Assumes one write per wr_en cycle.
module wdg_wr_qual
    import wdg_pkg::*;
(
    input  logic              wr_en,
    input  wdg_sel_e          sel,
    input  logic [BUS_W-1:0]  wdata,
    output logic              cfg_load,
    output logic              cfg_reject,
    output logic              feed_ok,
    output logic [HALF_W-1:0] new_tmo
);

    logic pattern_ok;

    // Guard checks on the raw write data.
    always_comb begin
        pattern_ok = cfg_word_ok(wdata);
        new_tmo    = wdata[HALF_W-1:0];
    end

    // Strobe generation per selected register.
    always_comb begin
        cfg_load   = wr_en && (sel == SEL_CFG) &&  pattern_ok;
        cfg_reject = wr_en && (sel == SEL_CFG) && !pattern_ok;
        feed_ok    = wr_en && (sel == SEL_FEED) && (wdata == FEED_KEY);
    end

endmodule

// File: rtl/wdg_cfg_store.sv
// Module: wdg_cfg_store
// Holds the accepted timeout and the sticky guard-error flag.
// Assumes cfg_load and cfg_reject are never high together.
module wdg_cfg_store
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_reject,
    input  logic [HALF_W-1:0] new_tmo,
    output logic [HALF_W-1:0] tmo,
    output logic              err
);

    // Timeout and error flag update; a good write clears the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo <= '0;
            err <= 1'b0;
        end else if (cfg_load) begin
            tmo <= new_tmo;
            err <= 1'b0;
        end else if (cfg_reject) begin
            err <= 1'b1;
        end
    end

endmodule

// File: rtl/wdg_countdown.sv
// Module: wdg_countdown
// Down-counter with expiry pulse. Priority: config load, feed, tick.
// Assumes tmo is the stored timeout; a zero timeout disarms counting.
module wdg_countdown
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [HALF_W-1:0] new_tmo,
    input  logic              feed_ok,
    input  logic              tick,
    input  logic [HALF_W-1:0] tmo,
    output logic [HALF_W-1:0] count,
    output logic              expire
);

    localparam logic [HALF_W-1:0] ONE = {{(HALF_W-1){1'b0}}, 1'b1};

    logic armed;
    logic last;

    // Arm and final-step detection.
    always_comb begin
        armed = (tmo != '0);
        last  = (count <= ONE);
    end

    // Count register and one-cycle expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (cfg_load) begin
                count <= new_tmo;
            end else if (!armed) begin
                count <= '0;
            end else if (feed_ok) begin
                count <= tmo;
            end else if (tick) begin
                if (last) begin
                    count  <= tmo;
                    expire <= 1'b1;
                end else begin
                    count <= count - ONE;
                end
            end
        end
    end

endmodule

// File: rtl/wdg_read_mux.sv
// Module: wdg_read_mux
// Combinational read data: config image, status word, zero elsewhere.
module wdg_read_mux
    import wdg_pkg::*;
(
    input  wdg_sel_e          sel,
    input  logic [HALF_W-1:0] tmo,
    input  logic [HALF_W-1:0] count,
    input  logic              err,
    output logic [BUS_W-1:0]  rdata
);

    localparam int unsigned PAD_W = BUS_W - 1 - HALF_W;

    // Register image selection.
    always_comb begin
        unique case (sel)
            SEL_CFG:  rdata = cfg_image(tmo);
            SEL_STAT: rdata = {err, {PAD_W{1'b0}}, count};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdg_guard.sv
// Module: wdg_guard
// Watchdog with pattern-guarded configuration and key-guarded feed.
// Assumes a single-cycle write bus and a synchronous tick input.
module wdg_guard
    import wdg_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] CFG_OFS  = 'h0,
    parameter logic [ADDR_W-1:0] FEED_OFS = 'h4,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              tick,
    output logic              sys_rst_req
);

    wdg_sel_e          reg_sel;
    logic              cfg_load;
    logic              cfg_reject;
    logic              feed_ok;
    logic [HALF_W-1:0] new_tmo;
    logic [HALF_W-1:0] tmo_q;
    logic [HALF_W-1:0] count_q;
    logic              err_q;

    wdg_addr_map #(
        .ADDR_W  (ADDR_W),
        .CFG_OFS (CFG_OFS),
        .FEED_OFS(FEED_OFS),
        .STAT_OFS(STAT_OFS)
    ) u_map (
        .addr(addr),
        .sel (reg_sel)
    );

    wdg_wr_qual u_qual (
        .wr_en     (wr_en),
        .sel       (reg_sel),
        .wdata     (wdata),
        .cfg_load  (cfg_load),
        .cfg_reject(cfg_reject),
        .feed_ok   (feed_ok),
        .new_tmo   (new_tmo)
    );

    wdg_cfg_store u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .cfg_reject(cfg_reject),
        .new_tmo   (new_tmo),
        .tmo       (tmo_q),
        .err       (err_q)
    );

    wdg_countdown u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_load(cfg_load),
        .new_tmo (new_tmo),
        .feed_ok (feed_ok),
        .tick    (tick),
        .tmo     (tmo_q),
        .count   (count_q),
        .expire  (sys_rst_req)
    );

    wdg_read_mux u_rd (
        .sel  (reg_sel),
        .tmo  (tmo_q),
        .count(count_q),
        .err  (err_q),
        .rdata(rdata)
    );

endmodule

// File: rtl/wdg_guard_chk.sv
// Module: wdg_guard_chk
// Property checker for wdg_guard, attached by bind below.
module wdg_guard_chk
    import wdg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input wdg_sel_e          sel,
    input logic [31:0]       wdata,
    input logic              tick,
    input logic              sys_rst_req,
    input logic [HALF_W-1:0] tmo,
    input logic [HALF_W-1:0] count,
    input logic              err
);

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CFG && cfg_word_ok(wdata))
        |=> (tmo == $past(wdata[HALF_W-1:0])) && (count == $past(wdata[HALF_W-1:0])));

    // R3
    bad_cfg_keeps_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CFG && !cfg_word_ok(wdata)) |=> $stable(tmo));

    // R3
    bad_cfg_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CFG && !cfg_word_ok(wdata)) |=> err);

    // R9
    good_cfg_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CFG && cfg_word_ok(wdata)) |=> !err);

    // R5
    bad_feed_holds_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_FEED && wdata != FEED_KEY && !tick) |=> $stable(count));

    // R6
    good_feed_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_FEED && wdata == FEED_KEY) |=> (count == $past(tmo)));

    // R7
    req_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> ($past(tick) && $past(tmo) != '0));

    // R10
    disarmed_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo == '0) |=> !sys_rst_req);

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= tmo);

endmodule

bind wdg_guard wdg_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .sel        (reg_sel),
    .wdata      (wdata),
    .tick       (tick),
    .sys_rst_req(sys_rst_req),
    .tmo        (tmo_q),
    .count      (count_q),
    .err        (err_q)
);

// File: tb/tb_wdg_guard.sv
// Scoreboard bench: driver tasks queue expected items tagged with the
// cycle they are due; a negedge monitor pops and compares them.
module tb_wdg_guard;

    localparam logic [3:0]  A_CFG  = 4'h0;
    localparam logic [3:0]  A_FEED = 4'h4;
    localparam logic [3:0]  A_STAT = 4'h8;
    localparam logic [31:0] KEY    = 32'hA55A55AA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        tick = 1'b0;
    logic        sys_rst_req;

    int cyc = 0;
    int slot = 0;
    int n_chk = 0;
    int n_err = 0;
    int req_cnt = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        bit          is_req;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    item_t keep_q[$];

    always #5 clk = ~clk;

    wdg_guard dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .tick       (tick),
        .sys_rst_req(sys_rst_req)
    );

    // Monitor: count cycles and reset pulses, check items now due.
    always @(negedge clk) begin
        logic [31:0] act;
        cyc = cyc + 1;
        if (rst_n && sys_rst_req) req_cnt = req_cnt + 1;
        keep_q = {};
        foreach (sbq[i]) begin
            if (sbq[i].due == cyc) begin
                act = sbq[i].is_req ? {31'b0, sys_rst_req} : rdata;
                n_chk = n_chk + 1;
                if (act !== sbq[i].exp) begin
                    n_err = n_err + 1;
                    $display("FAIL %s: actual=%h expected=%h", sbq[i].tag, act, sbq[i].exp);
                end
            end else begin
                keep_q.push_back(sbq[i]);
            end
        end
        sbq = keep_q;
    end

    task automatic step(input bit w, input logic [3:0] a, input logic [31:0] d, input bit t);
        @(posedge clk);
        #1;
        wr_en = w; addr = a; wdata = d; tick = t;
        slot = cyc;
    endtask

    task automatic exp_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        step(1'b0, a, 32'h0, 1'b0);
        sbq.push_back(item_t'{slot + 1, 1'b0, e, tag});
    endtask

    task automatic exp_req(input int ofs, input bit v, input string tag);
        sbq.push_back(item_t'{slot + ofs, 1'b1, {31'b0, v}, tag});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 4'h0, 32'h0, 1'b1);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Watchdog on the bench itself.
    initial begin
        repeat (5000) @(posedge clk);
        n_chk = n_chk + 1;
        n_err = n_err + 1;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    // Stimulus.
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        exp_rd(A_CFG, 32'hFFFF0000, "R1 cfg after reset");
        exp_req(1, 1'b0, "R1 req low after reset");
        exp_rd(A_STAT, 32'h0, "R1 status after reset");

        // R2 valid config, timeout 5
        step(1'b1, A_CFG, 32'hFFFA0005, 1'b0);
        exp_rd(A_CFG, 32'hFFFA0005, "R2 cfg image");
        exp_rd(A_STAT, 32'h00000005, "R2 count loaded");

        // R3 bad configs: no inverse, then one bit off
        step(1'b1, A_CFG, 32'h00000007, 1'b0);
        exp_rd(A_CFG, 32'hFFFA0005, "R3 timeout kept");
        exp_rd(A_STAT, 32'h80000005, "R3 error flag set");
        step(1'b1, A_CFG, 32'hFFFF0001, 1'b0);
        exp_rd(A_CFG, 32'hFFFA0005, "R3 near-miss kept");

        // R4 decrement on tick only
        ticks(2);
        exp_rd(A_STAT, 32'h80000003, "R4 two ticks");
        step(1'b0, 4'h0, 32'h0, 1'b0);
        step(1'b0, 4'h0, 32'h0, 1'b0);
        exp_rd(A_STAT, 32'h80000003, "R4 idle keeps count");

        // R5 wrong feed words
        step(1'b1, A_FEED, 32'hA55A55AB, 1'b0);
        step(1'b1, A_FEED, 32'h0, 1'b0);
        exp_rd(A_STAT, 32'h80000003, "R5 bad feed ignored");

        // R6 good feed
        step(1'b1, A_FEED, KEY, 1'b0);
        exp_rd(A_STAT, 32'h80000005, "R6 feed reload");

        // R7 expiry pulse
        ticks(4);
        exp_rd(A_STAT, 32'h80000001, "R4 count at one");
        step(1'b0, 4'h0, 32'h0, 1'b1);
        exp_req(1, 1'b0, "R7 before pulse");
        exp_req(2, 1'b1, "R7 pulse");
        exp_req(3, 1'b0, "R7 single cycle");
        step(1'b0, 4'h0, 32'h0, 1'b0);
        exp_rd(A_STAT, 32'h80000005, "R7 reload after expiry");

        // R8 feed on the expiring tick
        ticks(4);
        step(1'b1, A_FEED, KEY, 1'b1);
        exp_req(2, 1'b0, "R8 feed beats tick");
        exp_rd(A_STAT, 32'h80000005, "R8 feed reloaded");

        // R8/R9 valid config with tick, clears error
        step(1'b1, A_CFG, 32'hFFFD0002, 1'b1);
        exp_rd(A_STAT, 32'h00000002, "R9 error cleared, R8 cfg beats tick");
        exp_rd(A_CFG, 32'hFFFD0002, "R2 new cfg image");
        ticks(4);
        exp_rd(A_STAT, 32'h00000002, "R7 two expiries reload");

        // R10 disarm
        step(1'b1, A_CFG, 32'hFFFF0000, 1'b0);
        ticks(10);
        exp_rd(A_STAT, 32'h00000000, "R10 no counting");
        step(1'b1, A_FEED, KEY, 1'b0);
        exp_rd(A_STAT, 32'h00000000, "R10 feed no effect");
        exp_rd(A_CFG, 32'hFFFF0000, "R10 cfg image");

        // R11 read map
        exp_rd(A_FEED, 32'h0, "R11 feed reads zero");
        exp_rd(4'hC, 32'h0, "R11 unmapped reads zero");

        repeat (4) step(1'b0, 4'h0, 32'h0, 1'b0);
        n_chk = n_chk + 1;
        if (req_cnt != 3) begin
            n_err = n_err + 1;
            $display("FAIL R10 total pulses: actual=%0d expected=%0d", req_cnt, 3);
        end
        report();
    end

endmodule